// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on one channel of a data converter's digital output path. It takes the 14-bit sample word and either forwards it or puts a known test word in its place, depending on a 3-bit mode code held in the configuration bank. The test words are three constant levels, a checkerboard, a long and a short pseudo-random sequence, and an all-ones/all-zeros toggle. Downstream logic and the lab equipment on the far side of the link can use these words to check wiring, bit order and timing without a live analog input.

The output is registered and lags the input by one cycle. Only cycles with `valid_i` high are samples. The checkerboard/toggle phase and both pseudo-random generators advance once per valid sample, whatever mode is selected. When the mode changes, the next word therefore follows from the samples that came before it, not from a restart. Each pseudo-random generator has its own synchronous restart input that holds it at its seed. Samples are coded in offset binary.

Top module: `test_pattern_gen`

## Requirements
- R1: With mode 0, `sample_o` equals the `sample_i` of the previous valid cycle. `valid_o` is `valid_i` delayed by one clock.
- R2: With mode 1, the output word is midscale, 0x2000.
- R3: With mode 2 the output word is 0x3FFF (positive full scale). With mode 3 it is 0x0000 (negative full scale).
- R4: A phase bit is cleared by reset and toggles on every valid sample in any mode. With mode 4 the output word is 0x2AAA when the phase is 0 and 0x1555 when it is 1.
- R5: With mode 7 the output word is 0x3FFF when the phase is 0 and 0x0000 when it is 1.
- R6: The long sequence is a 23-bit shift register seeded to all ones. On each step it shifts left and takes bit22 XOR bit17 into bit 0 (x^23+x^18+1). It steps on every valid sample unless its restart input is high. With mode 5 the output word is state bits 13..0, taken before the step.
- R7: The short sequence is a 9-bit shift register seeded to all ones. On each step it shifts left and takes bit8 XOR bit4 into bit 0 (x^9+x^5+1). It steps on every valid sample unless its restart input is high. With mode 6 the output word is bit i of the word = state bit (i mod 9), that is {state[4:0], state[8:0]}, taken before the step.
- R8: While a restart input is high, that sequence's state is its seed, and a valid sample in its mode outputs the seed word 0x3FFF. The first valid sample after release also outputs 0x3FFF.
- R9: A cycle with `valid_i` low changes neither `sample_o` nor any sequence or phase state.
- R10: After reset `sample_o` is 0 and `valid_o` is 0, the phase is 0 and both sequences hold their seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Converter sample, offset binary |
| valid_i | input | 1 | Sample qualifier |
| mode_i | input | 3 | Pattern select code |
| long_rst_i | input | 1 | Synchronous restart of long sequence |
| short_rst_i | input | 1 | Synchronous restart of short sequence |
| sample_o | output | 14 | Selected word, registered |
| valid_o | output | 1 | Output qualifier |

## Verification
The assertions assume that the mode code and both restart inputs are synchronous to `clk_i` and stable around each rising edge. They also assume that a mode change takes effect on the next valid sample, with no settling time. The stimulus drives all inputs on the falling edge, so they are steady at every sampling edge. It sweeps every mode code, with random gaps in `valid_i`. It pulses the restarts both inside and outside their own modes. It ends with a mixed run in which the mode, the data and the restarts all change freely from cycle to cycle.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    MODE_PASS     = 3'd0,
    MODE_MID      = 3'd1,
    MODE_POS_FS   = 3'd2,
    MODE_NEG_FS   = 3'd3,
    MODE_CHECKER  = 3'd4,
    MODE_PN_LONG  = 3'd5,
    MODE_PN_SHORT = 3'd6,
    MODE_TOGGLE   = 3'd7
  } tpg_mode_e;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int unsigned STATE_W = 23,
  parameter int unsigned TAP     = 18,
  parameter int unsigned OUT_W   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_rst_i,
  input  logic             adv_i,
  output logic [OUT_W-1:0] word_o
);
  localparam logic [STATE_W-1:0] SEED = '1;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] cur;
  logic               fb;

  // restart forces the seed immediately so the held word is the seed word
  assign cur = seq_rst_i ? SEED : state_q;
  assign fb  = state_q[STATE_W-1] ^ state_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= SEED;
    else if (seq_rst_i) state_q <= SEED;
    else if (adv_i)     state_q <= {state_q[STATE_W-2:0], fb};
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_word
    assign word_o[i] = cur[i % STATE_W];
  end
endmodule

// File: rtl/tpg_phase.sv
module tpg_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_o <= 1'b0;
    else if (adv_i) phase_o <= ~phase_o;
  end
endmodule

// File: rtl/tpg_mux.sv
module tpg_mux
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              phase_i,
  input  logic [DATA_W-1:0] long_word_i,
  input  logic [DATA_W-1:0] short_word_i,
  output logic [DATA_W-1:0] word_o
);
  function automatic logic [DATA_W-1:0] alt_bits(input logic odd);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = ((i % 2) == 1) ? odd : ~odd;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] W_MID   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] W_ONES  = '1;
  localparam logic [DATA_W-1:0] W_ZEROS = '0;
  localparam logic [DATA_W-1:0] W_CHK_A = alt_bits(1'b1);
  localparam logic [DATA_W-1:0] W_CHK_B = alt_bits(1'b0);

  tpg_mode_e mode;
  assign mode = tpg_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_PASS:     word_o = sample_i;
      MODE_MID:      word_o = W_MID;
      MODE_POS_FS:   word_o = W_ONES;
      MODE_NEG_FS:   word_o = W_ZEROS;
      MODE_CHECKER:  word_o = phase_i ? W_CHK_B : W_CHK_A;
      MODE_PN_LONG:  word_o = long_word_i;
      MODE_PN_SHORT: word_o = short_word_i;
      MODE_TOGGLE:   word_o = phase_i ? W_ZEROS : W_ONES;
      default:       word_o = sample_i;
    endcase
  end
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W    = 14,
  parameter int unsigned LONG_W    = 23,
  parameter int unsigned LONG_TAP  = 18,
  parameter int unsigned SHORT_W   = 9,
  parameter int unsigned SHORT_TAP = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic              long_rst_i,
  input  logic              short_rst_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              valid_o
);
  logic              phase;
  logic [DATA_W-1:0] long_word;
  logic [DATA_W-1:0] short_word;
  logic [DATA_W-1:0] sel_word;

  tpg_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (valid_i),
    .phase_o(phase)
  );

  tpg_lfsr #(.STATE_W(LONG_W), .TAP(LONG_TAP), .OUT_W(DATA_W)) u_long (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seq_rst_i(long_rst_i),
    .adv_i    (valid_i),
    .word_o   (long_word)
  );

  tpg_lfsr #(.STATE_W(SHORT_W), .TAP(SHORT_TAP), .OUT_W(DATA_W)) u_short (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seq_rst_i(short_rst_i),
    .adv_i    (valid_i),
    .word_o   (short_word)
  );

  tpg_mux #(.DATA_W(DATA_W)) u_mux (
    .mode_i      (mode_i),
    .sample_i    (sample_i),
    .phase_i     (phase),
    .long_word_i (long_word),
    .short_word_i(short_word),
    .word_o      (sel_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= sel_word;
    end
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int unsigned DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] sample_i,
  input logic              valid_i,
  input logic [2:0]        mode_i,
  input logic              long_rst_i,
  input logic              short_rst_i,
  input logic [DATA_W-1:0] sample_o,
  input logic              valid_o
);
  localparam logic [DATA_W-1:0] MID  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ONES = '1;

  a_r1_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd0 |=> sample_o == $past(sample_i));
  a_r1_valid_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_valid_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd1 |=> sample_o == MID);
  a_r3_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd2 |=> sample_o == ONES);
  a_r3_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd3 |=> sample_o == '0);
  a_r4_checker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd4 |=> (sample_o == (ONES / 3 * 2)) || (sample_o == ONES / 3));
  a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd7 |=> sample_o == ONES || sample_o == '0);
  a_r8_long_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd5 && long_rst_i |=> sample_o == ONES);
  a_r8_short_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 3'd6 && short_rst_i |=> sample_o == ONES);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sample_o));
endmodule

bind test_pattern_gen tpg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_i   (sample_i),
  .valid_i    (valid_i),
  .mode_i     (mode_i),
  .long_rst_i (long_rst_i),
  .short_rst_i(short_rst_i),
  .sample_o   (sample_o),
  .valid_o    (valid_o)
);

// File: tb/tb_test_pattern_gen.sv
module tb_test_pattern_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] sample_i = '0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        long_rst_i = 1'b0;
  logic        short_rst_i = 1'b0;
  logic [13:0] sample_o;
  logic        valid_o;

  always #10 clk_i = ~clk_i;

  test_pattern_gen dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit chk_en = 0;

  // behavioural reference
  int unsigned ls, ss;
  bit          ph;
  logic [13:0] exp_s;
  bit          exp_v;
  string       tag;

  function automatic logic [13:0] pn_word(int unsigned s, int w);
    logic [13:0] r;
    for (int i = 0; i < 14; i++) r[i] = ((s >> (i % w)) & 1) != 0;
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ls = 32'h7FFFFF; ss = 32'h1FF; ph = 0; exp_s = '0; exp_v = 0; tag = "R10";
    end else begin
      int unsigned lc, sc;
      lc = long_rst_i ? 32'h7FFFFF : ls;
      sc = short_rst_i ? 32'h1FF : ss;
      exp_v = valid_i;
      if (valid_i) begin
        case (mode_i)
          3'd0: begin exp_s = sample_i; tag = "R1"; end
          3'd1: begin exp_s = 14'd8192; tag = "R2"; end
          3'd2: begin exp_s = 14'd16383; tag = "R3"; end
          3'd3: begin exp_s = 14'd0; tag = "R3"; end
          3'd4: begin exp_s = ph ? 14'd5461 : 14'd10922; tag = "R4"; end
          3'd5: begin exp_s = pn_word(lc, 23); tag = long_rst_i ? "R8" : "R6"; end
          3'd6: begin exp_s = pn_word(sc, 9); tag = short_rst_i ? "R8" : "R7"; end
          default: begin exp_s = ph ? 14'd0 : 14'd16383; tag = "R5"; end
        endcase
        ph = ~ph;
      end else tag = "R9";
      if (long_rst_i) ls = 32'h7FFFFF;
      else if (valid_i) ls = ((ls << 1) | (((ls >> 22) ^ (ls >> 17)) & 1)) & 32'h7FFFFF;
      if (short_rst_i) ss = 32'h1FF;
      else if (valid_i) ss = ((ss << 1) | (((ss >> 8) ^ (ss >> 4)) & 1)) & 32'h1FF;
    end
  end

  always @(negedge clk_i) begin
    if (chk_en && !done) begin
      checks++;
      if (sample_o !== exp_s) begin
        errors++;
        $display("FAIL %s sample_o actual=%h expected=%h t=%0t", tag, sample_o, exp_s, $time);
      end
      checks++;
      if (valid_o !== exp_v) begin
        errors++;
        $display("FAIL R1 valid_o actual=%b expected=%b t=%0t", valid_o, exp_v, $time);
      end
    end
  end

  task automatic drive(bit v, logic [2:0] m, logic [13:0] d, bit lr, bit sr);
    @(negedge clk_i);
    valid_i = v; mode_i = m; sample_i = d; long_rst_i = lr; short_rst_i = sr;
  endtask

  initial begin
    repeat (2) @(posedge clk_i);
    chk_en = 1;                      // R10 reset values checked here
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // each mode with gaps; restarts pulsed mid-run (R8)
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 60; c++) begin
        drive(($urandom % 4) != 0, m[2:0], 14'($urandom),
              (m == 5 && c >= 20 && c < 26) || (c == 40),
              (m == 6 && c >= 20 && c < 26) || (c == 45));
      end
    end
    // long stretches of each sequence with steady valid (R6, R7)
    for (int c = 0; c < 600; c++) drive(1, 3'd5, '0, 0, 0);
    for (int c = 0; c < 600; c++) drive(1, 3'd6, '0, 0, 0);
    // mixed run
    for (int c = 0; c < 2000; c++) begin
      drive(($urandom % 3) != 0, 3'($urandom), 14'($urandom),
            ($urandom % 17) == 0, ($urandom % 13) == 0);
    end
    drive(0, 3'd0, '0, 0, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule